// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, from the destination address at the head of a received frame, whether a MAC receive path should keep the frame or drop it. Address bytes arrive one per qualified cycle. Within each byte the bits arrive least significant bit first. The block collects the six bytes and runs a CRC-32 over them as they stream in. One cycle after the last address byte it presents a verdict. The verdict stays steady until the next frame starts.

The verdict follows a fixed priority chain. A broadcast destination is checked first. A multicast destination is checked next. It goes either to a group hash table or to an exact compare against a programmed pause address, and the flow-control enable picks which. A unicast destination is checked last. It is compared exactly with the station address and falls back to a separate individual hash table. Two active-low match flags report which mechanism fired. A pause-candidate flag marks destinations that a pause frame could use. An external pause-valid input, driven by later opcode parsing, vetoes acceptance of such frames.

Top module: `daf_filter`

## Requirements
- R1: After reset, and at any time no complete address is held, `decision_valid` and `accept` are 0, and `exact_match_n` and `hash_match_n` are 1.
- R2: A byte is taken when `byte_valid` is 1. A byte taken with `sof` starts a new address as byte 0. Later bytes without `sof` fill bytes 1 to 5 in order. Bytes beyond the sixth, and bytes seen before any `sof`, are ignored. `decision_valid` is 1 from the cycle after the sixth byte is taken until a new `sof` byte. The verdict does not change during that time.
- R3: Byte k of the address occupies bits [8k+7:8k] of the 48-bit address value. The same layout applies to `station_addr` and `pause_addr`. An all-ones address is broadcast. It sets `is_bcast` and is accepted exactly when `bcast_reject` is 0. Both match flags stay 1.
- R4: Bit 0 of the first address byte is the group bit. When it is 1 and the address is not broadcast, `is_mcast` is 1.
- R5: A multicast address with `flow_ctrl_en` at 0 is accepted when its entry in `group_hash` is 1. That hit drives `hash_match_n` to 0.
- R6: A multicast address with `flow_ctrl_en` at 1 is accepted only when it equals `pause_addr`. That match drives `exact_match_n` to 0. The group hash table is not consulted in this case.
- R7: A unicast address equal to `station_addr` is accepted and drives `exact_match_n` to 0.
- R8: A unicast address that differs from `station_addr` is accepted when its entry in `indiv_hash` is 1. That hit drives `hash_match_n` to 0.
- R9: The hash index is bits [31:26] of a CRC-32 register. The register starts at all ones and takes the 48 address bits in arrival order, using the reflected polynomial 0xEDB88320, with no final inversion. Index bit 5 selects the upper (1) or lower (0) 32-entry half of a table. Index bits 4:0 select the entry within that half.
- R10: `pause_candidate` is 1 when `flow_ctrl_en` is 1 and the held address equals `pause_addr` or `station_addr`. While it is 1 and `pause_frame_valid` is 1, `accept` is 0.
- R11: An address that matches no rule is rejected, and both match flags stay 1. `accept` is never 1 unless there is a broadcast or a flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Marks the first address byte of a frame |
| byte_valid | input | 1 | Qualifies byte_data |
| byte_data | input | 8 | Address byte, bit 0 received first |
| station_addr | input | 48 | Station unicast address |
| pause_addr | input | 48 | Designated pause destination |
| group_hash | input | 64 | Multicast hash table |
| indiv_hash | input | 64 | Unicast fallback hash table |
| bcast_reject | input | 1 | Drop broadcast frames when 1 |
| flow_ctrl_en | input | 1 | Selects pause exact compare for multicast |
| pause_frame_valid | input | 1 | Frame was parsed as a valid pause frame |
| decision_valid | output | 1 | A full address is held and the verdict is valid |
| accept | output | 1 | Keep the frame |
| is_bcast | output | 1 | Destination is broadcast |
| is_mcast | output | 1 | Destination is non-broadcast multicast |
| exact_match_n | output | 1 | Active-low exact-compare hit |
| hash_match_n | output | 1 | Active-low hash-table hit |
| pause_candidate | output | 1 | Destination is usable by a pause frame |

## Verification
The bench builds the block with its default parameters: six address bytes and 64-entry tables. So the full 48-bit compares and both halves of each table are in play. The bench derives each address's hash index with its own forward-shifting CRC and then sets or clears single table bits. This lets it reach a hit, a miss, and a bit set only in the opposite half at the same offset. Stimulus also covers idle gaps between bytes, surplus bytes after the sixth, stray bytes before any start of frame, and both settings of flow control, broadcast reject and pause validity.

// File: rtl/daf_pkg.sv
package daf_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

  // Advance a reflected CRC-32 register by one byte, bit 0 of the byte first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                input logic [7:0]  b);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ b[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

endpackage

// File: rtl/daf_collect.sv
module daf_collect #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sof,
  input  logic                 byte_valid,
  input  logic [7:0]           byte_data,
  output logic [ADDR_W-1:0]    da,
  output logic [HASH_BITS-1:0] hash_idx,
  output logic                 addr_ready,
  output logic                 last_take
);
  import daf_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             open_q;
  logic [31:0]      crc_q;
  logic             take_first, take_next;

  assign take_first = byte_valid && sof;
  assign take_next  = byte_valid && !sof && open_q && (cnt_q < CNT_W'(ADDR_BYTES));
  assign last_take  = (take_first && ADDR_BYTES == 1) ||
                      (take_next && cnt_q == CNT_W'(ADDR_BYTES - 1));

  generate
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n)
          da[8*k +: 8] <= '0;
        else if (take_first)
          da[8*k +: 8] <= (k == 0) ? byte_data : 8'h00;
        else if (take_next && cnt_q == CNT_W'(k))
          da[8*k +: 8] <= byte_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
      crc_q  <= CRC_SEED;
    end else if (take_first) begin
      cnt_q  <= CNT_W'(1);
      open_q <= 1'b1;
      crc_q  <= crc_step_byte(CRC_SEED, byte_data);
    end else if (take_next) begin
      cnt_q  <= cnt_q + CNT_W'(1);
      crc_q  <= crc_step_byte(crc_q, byte_data);
    end
  end

  assign addr_ready = open_q && (cnt_q == CNT_W'(ADDR_BYTES));
  assign hash_idx   = crc_q[31 -: HASH_BITS];

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BYTES));

  assert_ready_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> addr_ready);

  assert_hold_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ready && !take_first) |=> ($stable(da) && $stable(hash_idx) && addr_ready));

endmodule

// File: rtl/daf_hash_lookup.sv
module daf_hash_lookup #(
  parameter int HASH_BITS = 6,
  localparam int TABLE_N = 1 << HASH_BITS,
  localparam int HALF_N  = TABLE_N / 2
) (
  input  logic [HASH_BITS-1:0] idx,
  input  logic [TABLE_N-1:0]   hash_tbl,
  output logic                 hit
);
  generate
    if (HASH_BITS > 1) begin : g_split
      logic [HALF_N-1:0]    upper_half, lower_half;
      logic [HASH_BITS-2:0] offset;
      assign upper_half = hash_tbl[TABLE_N-1:HALF_N];
      assign lower_half = hash_tbl[HALF_N-1:0];
      assign offset     = idx[HASH_BITS-2:0];
      assign hit = idx[HASH_BITS-1] ? upper_half[offset] : lower_half[offset];
    end else begin : g_flat
      assign hit = hash_tbl[idx];
    end
  endgenerate
endmodule

// File: rtl/daf_classify.sv
module daf_classify #(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] da,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic [ADDR_W-1:0] pause_addr,
  output logic              bcast,
  output logic              group_bit,
  output logic              station_eq,
  output logic              pause_eq
);
  assign bcast      = &da;
  assign group_bit  = da[0];
  assign station_eq = (da == station_addr);
  assign pause_eq   = (da == pause_addr);
endmodule

// File: rtl/daf_filter.sv
module daf_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  localparam int ADDR_W  = 8 * ADDR_BYTES,
  localparam int TABLE_N = 1 << HASH_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic [ADDR_W-1:0] pause_addr,
  input  logic [TABLE_N-1:0] group_hash,
  input  logic [TABLE_N-1:0] indiv_hash,
  input  logic              bcast_reject,
  input  logic              flow_ctrl_en,
  input  logic              pause_frame_valid,
  output logic              decision_valid,
  output logic              accept,
  output logic              is_bcast,
  output logic              is_mcast,
  output logic              exact_match_n,
  output logic              hash_match_n,
  output logic              pause_candidate
);

  logic [ADDR_W-1:0]    da;
  logic [HASH_BITS-1:0] hash_idx;
  logic                 addr_ready, last_take;
  logic                 bcast, group_bit, station_eq, pause_eq;
  logic                 group_hit, indiv_hit;
  logic                 route_accept;

  daf_collect #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_collect (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_valid(byte_valid),
    .byte_data(byte_data), .da(da), .hash_idx(hash_idx),
    .addr_ready(addr_ready), .last_take(last_take)
  );

  daf_classify #(.ADDR_W(ADDR_W)) u_classify (
    .da(da), .station_addr(station_addr), .pause_addr(pause_addr),
    .bcast(bcast), .group_bit(group_bit),
    .station_eq(station_eq), .pause_eq(pause_eq)
  );

  daf_hash_lookup #(.HASH_BITS(HASH_BITS)) u_group_lookup (
    .idx(hash_idx), .hash_tbl(group_hash), .hit(group_hit)
  );

  daf_hash_lookup #(.HASH_BITS(HASH_BITS)) u_indiv_lookup (
    .idx(hash_idx), .hash_tbl(indiv_hash), .hit(indiv_hit)
  );

  // Priority chain: broadcast, then multicast, then unicast.
  always_comb begin
    route_accept  = 1'b0;
    exact_match_n = 1'b1;
    hash_match_n  = 1'b1;
    if (addr_ready) begin
      if (bcast) begin
        route_accept = !bcast_reject;
      end else if (group_bit) begin
        if (!flow_ctrl_en) begin
          if (group_hit) begin
            hash_match_n = 1'b0;
            route_accept = 1'b1;
          end
        end else if (pause_eq) begin
          exact_match_n = 1'b0;
          route_accept  = 1'b1;
        end
      end else begin
        if (station_eq) begin
          exact_match_n = 1'b0;
          route_accept  = 1'b1;
        end else if (indiv_hit) begin
          hash_match_n = 1'b0;
          route_accept = 1'b1;
        end
      end
    end
  end

  assign pause_candidate = addr_ready && flow_ctrl_en && (pause_eq || station_eq);
  assign accept          = route_accept && !(pause_candidate && pause_frame_valid);
  assign decision_valid  = addr_ready;
  assign is_bcast        = addr_ready && bcast;
  assign is_mcast        = addr_ready && group_bit && !bcast;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !decision_valid |-> (!accept && exact_match_n && hash_match_n));

  assert_valid_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> decision_valid);

  assert_bcast_no_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_bcast |-> (exact_match_n && hash_match_n && !is_mcast));

  assert_pause_veto_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_candidate && pause_frame_valid) |-> !accept);

  assert_single_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!exact_match_n && !hash_match_n));

  assert_accept_reason_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (is_bcast || !exact_match_n || !hash_match_n));

  assert_fc_no_group_hash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mcast && flow_ctrl_en) |-> hash_match_n);

endmodule

// File: tb/tb_daf_filter.sv
module tb_daf_filter;
  localparam int NB = 6;
  localparam int AW = 8 * NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [AW-1:0] station_addr = 48'h5544_3322_1100;
  logic [AW-1:0] pause_addr   = 48'h0180_C200_0001;
  logic [63:0] group_hash = '0, indiv_hash = '0;
  logic bcast_reject = 1'b0, flow_ctrl_en = 1'b0, pause_frame_valid = 1'b0;
  logic decision_valid, accept, is_bcast, is_mcast;
  logic exact_match_n, hash_match_n, pause_candidate;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  daf_filter dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_valid(byte_valid),
    .byte_data(byte_data), .station_addr(station_addr), .pause_addr(pause_addr),
    .group_hash(group_hash), .indiv_hash(indiv_hash), .bcast_reject(bcast_reject),
    .flow_ctrl_en(flow_ctrl_en), .pause_frame_valid(pause_frame_valid),
    .decision_valid(decision_valid), .accept(accept), .is_bcast(is_bcast),
    .is_mcast(is_mcast), .exact_match_n(exact_match_n), .hash_match_n(hash_match_n),
    .pause_candidate(pause_candidate)
  );

  // Reference state: received bytes in a queue.
  logic [7:0] rx_q[$];
  bit started = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rx_q.delete();
      started = 0;
    end else if (byte_valid) begin
      if (sof) begin
        rx_q.delete();
        rx_q.push_back(byte_data);
        started = 1;
      end else if (started && rx_q.size() < NB) begin
        rx_q.push_back(byte_data);
      end
    end
  end

  // Hash index via a forward-shifting CRC; the index is the bit-reversed low six bits.
  function automatic int ref_index(input logic [AW-1:0] a);
    logic [31:0] c;
    logic top;
    int idx;
    c = 32'hFFFFFFFF;
    for (int n = 0; n < AW; n++) begin
      top = c[31] ^ a[n];
      c = c << 1;
      if (top) c = c ^ 32'h04C11DB7;
    end
    idx = 0;
    for (int k = 0; k < 6; k++) if (c[5-k]) idx = idx + (1 << k);
    return idx;
  endfunction

  task automatic check(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  // Compare against the reference on every falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      logic [AW-1:0] a;
      logic e_valid, e_acc, e_b, e_m, e_em, e_hm, e_pc, raw;
      string acc_tag;
      e_valid = started && (rx_q.size() == NB);
      check("R2", "decision_valid", decision_valid, e_valid);
      if (!e_valid) begin
        check("R1", "accept idle", accept, 1'b0);
        check("R1", "exact_match_n idle", exact_match_n, 1'b1);
        check("R1", "hash_match_n idle", hash_match_n, 1'b1);
      end else begin
        a = '0;
        foreach (rx_q[i]) a[8*i +: 8] = rx_q[i];
        e_b = (a == {AW{1'b1}});
        e_m = a[0] && !e_b;
        e_em = 1; e_hm = 1; raw = 0; acc_tag = "R11";
        if (e_b) begin
          raw = !bcast_reject; acc_tag = "R3";
        end else if (e_m && !flow_ctrl_en) begin
          if (group_hash[ref_index(a)]) begin raw = 1; e_hm = 0; acc_tag = "R5"; end
        end else if (e_m) begin
          if (a == pause_addr) begin raw = 1; e_em = 0; acc_tag = "R6"; end
        end else if (a == station_addr) begin
          raw = 1; e_em = 0; acc_tag = "R7";
        end else if (indiv_hash[ref_index(a)]) begin
          raw = 1; e_hm = 0; acc_tag = "R8";
        end
        e_pc = flow_ctrl_en && (a == pause_addr || a == station_addr);
        e_acc = raw;
        if (e_pc && pause_frame_valid) begin e_acc = 0; acc_tag = "R10"; end
        check("R3", "is_bcast", is_bcast, e_b);
        check("R4", "is_mcast", is_mcast, e_m);
        check(e_m ? "R6" : "R7", "exact_match_n", exact_match_n, e_em);
        check(e_m ? "R5" : "R8", "hash_match_n", hash_match_n, e_hm);
        check("R10", "pause_candidate", pause_candidate, e_pc);
        check(acc_tag, "accept", accept, e_acc);
      end
    end
  end

  task automatic send_addr(input logic [AW-1:0] a, input int gap, input int extra);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk); #1;
      sof = (i == 0); byte_valid = 1'b1; byte_data = a[8*i +: 8];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); #1;
        sof = 1'b0; byte_valid = 1'b0; byte_data = 8'hA5;
      end
    end
    for (int e = 0; e < extra; e++) begin
      @(negedge clk); #1;
      sof = 1'b0; byte_valid = 1'b1; byte_data = 8'hFF ^ 8'(e);
    end
    @(negedge clk); #1;
    sof = 1'b0; byte_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] mc, uc;
    int gi, ui;
    mc = 48'h0000_0000_0033;
    uc = 48'h0000_0000_1234;
    gi = ref_index(mc);
    ui = ref_index(uc);
    repeat (3) @(negedge clk);
    check("R1", "decision_valid in reset", decision_valid, 1'b0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", "accept after reset", accept, 1'b0);
    check("R1", "exact_match_n after reset", exact_match_n, 1'b1);

    // R2: stray bytes before any start are ignored
    repeat (7) begin
      @(negedge clk); #1; byte_valid = 1'b1; byte_data = 8'hFF;
    end
    @(negedge clk); #1; byte_valid = 1'b0;
    @(negedge clk);
    check("R2", "no decision from stray bytes", decision_valid, 1'b0);

    // R3: broadcast accept and reject
    send_addr({AW{1'b1}}, 0, 0);
    check("R3", "broadcast accepted", accept, 1'b1);
    bcast_reject = 1'b1;
    send_addr({AW{1'b1}}, 1, 0);
    check("R3", "broadcast rejected", accept, 1'b0);
    bcast_reject = 1'b0;

    // R5 / R9: group hash hit, then the same offset in the other half only
    group_hash = 64'd1 << gi;
    send_addr(mc, 0, 0);
    check("R9", "group hash hit at computed index", hash_match_n, 1'b0);
    group_hash = 64'd1 << (gi ^ 32);
    send_addr(mc, 0, 0);
    check("R9", "opposite half does not hit", hash_match_n, 1'b1);
    check("R11", "unmatched multicast rejected", accept, 1'b0);

    // R6: flow control on, pause exact match, group hash ignored
    flow_ctrl_en = 1'b1;
    group_hash = 64'd1 << gi;
    send_addr(mc, 0, 0);
    check("R6", "group hash bypassed", accept, 1'b0);
    send_addr(pause_addr, 2, 0);
    check("R6", "pause address accepted", accept, 1'b1);
    pause_frame_valid = 1'b1;
    @(negedge clk);
    check("R10", "valid pause frame vetoed", accept, 1'b0);

    // R7 / R10: station address, with and without pause veto
    send_addr(station_addr, 0, 0);
    check("R10", "pause to station vetoed", accept, 1'b0);
    pause_frame_valid = 1'b0;
    flow_ctrl_en = 1'b0;
    send_addr(station_addr, 0, 3);
    check("R7", "station accepted with surplus bytes", accept, 1'b1);
    check("R2", "surplus bytes keep decision", decision_valid, 1'b1);

    // R8 / R11: unicast fallback hash
    indiv_hash = 64'd1 << ui;
    send_addr(uc, 1, 0);
    check("R8", "individual hash accept", hash_match_n, 1'b0);
    indiv_hash = '0;
    @(negedge clk);
    check("R11", "no match rejected", accept, 1'b0);

    // R2: new start mid-hold clears decision
    @(negedge clk); #1; sof = 1'b1; byte_valid = 1'b1; byte_data = 8'hFF;
    @(negedge clk); #1; sof = 1'b0; byte_valid = 1'b0;
    @(negedge clk);
    check("R2", "new start clears decision", decision_valid, 1'b0);
    repeat (3) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule